// File: doc/BRIEF.md
# Serial Network Address CRC Checker

This block takes in a 64-bit network address for a single-wire device bus, one bit per valid strobe, least significant bit first. It places each bit in an address register and splits the result into three fields: an 8-bit family code, a 48-bit serial number and an 8-bit check byte. While the first 56 bits arrive, it feeds each bit through an 8-bit CRC shift register with XOR feedback. After the last bit it compares the computed CRC with the check byte carried in the address.

A host starts each address with a clear strobe. It then presents the bits with a bit-valid strobe, at any rate and with gaps of any length. When the 64th bit has been taken, a one-cycle done pulse appears. A CRC-OK flag then holds the result of the compare until the next clear. A separate flag shows when the received family code equals 8'h30.

Top module: `owa_addr_checker`

## Requirements
- R1: After a synchronous reset, every field output, the computed CRC, done_o, crc_ok_o and family_match_o are zero, and the block is idle.
- R2: While idle (after reset, before the first clear strobe), bit-valid strobes change nothing. All outputs stay zero, and a later address is not affected by them.
- R3: A clear strobe zeroes the address fields, the computed CRC and crc_ok_o, and restarts counting at bit 0. A bit presented in the same cycle as clear is discarded.
- R4: The k-th accepted bit (k = 0..63) is stored at address bit k. family_o is address bits 7:0, serial_o is bits 55:8 and rx_crc_o is bits 63:56.
- R5: calc_crc_o starts at 8'h00 after clear. For each of the first 56 accepted bits it updates as follows: feedback = bit XOR crc[0], then crc = (crc >> 1) XOR (feedback ? 8'h8C : 8'h00). Bits 56..63 leave it unchanged.
- R6: done_o is high for exactly one cycle, in the cycle after the 64th bit is accepted. It is never high at any other time.
- R7: crc_ok_o is set together with done_o exactly when calc_crc_o equals rx_crc_o. Equivalently, it is set when running all 64 bits through the R5 update leaves 8'h00. It holds its value until the next clear.
- R8: Once 64 bits have been accepted, further bit-valid strobes are ignored until a clear. The fields, the CRC and crc_ok_o keep their values.
- R9: family_match_o is high exactly when at least 8 bits of the current address have been accepted and family_o equals 8'h30.
- R10: A clear strobe in the middle of an address aborts it. The next 64 accepted bits form a fresh address whose fields and result do not depend on the aborted one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clear_i | input | 1 | Start/clear strobe: aborts and begins a new address |
| bit_vld_i | input | 1 | Qualifies bit_i for one cycle |
| bit_i | input | 1 | Serial address bit |
| family_o | output | 8 | Received family code (address bits 7:0) |
| serial_o | output | 48 | Received serial number (address bits 55:8) |
| rx_crc_o | output | 8 | Received check byte (address bits 63:56) |
| calc_crc_o | output | 8 | CRC computed over the first 56 bits |
| done_o | output | 1 | One-cycle pulse after the 64th bit |
| crc_ok_o | output | 1 | Computed CRC equals received check byte |
| family_match_o | output | 1 | Family code received and equal to 8'h30 |

## Verification
The clear strobe and a bit-valid strobe can arrive in the same cycle, and so can the 64th bit and a clear. In both cases clear must win and the bit must be dropped. The bench provokes these cases with a clear and a set bit presented together, both at the start of an address and on its final bit. It judges them by whether family_o stays zero and whether done_o stays low. A behavioural model compares every output on every clock against a CRC recomputed from scratch over the bits the model has accepted.

// File: rtl/owa_pkg.sv
package owa_pkg;
    localparam int ADDR_W  = 64;
    localparam int CRC_W   = 8;
    localparam int FAM_W   = 8;
    localparam int SER_W   = 48;
    localparam int BODY_W  = FAM_W + SER_W;
    localparam int CNT_W   = $clog2(ADDR_W + 1);
    localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;
    localparam logic [FAM_W-1:0] FAMILY_ID = 8'h30;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_FULL = 2'd2
    } owa_state_e;
endpackage

// File: rtl/owa_seq_ctrl.sv
module owa_seq_ctrl #(
    parameter int ADDR_W = owa_pkg::ADDR_W,
    parameter int BODY_W = owa_pkg::BODY_W,
    parameter int CNT_W  = $clog2(ADDR_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             bit_vld_i,
    output logic             accept_o,
    output logic             body_o,
    output logic             tail_o,
    output logic             last_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    import owa_pkg::*;

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] BODY_END = CNT_W'(BODY_W);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_W);

    typedef struct packed {
        owa_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  accept;

    always_comb begin
        accept      = (ctrl_q.state == ST_RECV) && bit_vld_i && !clear_i;
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        if (clear_i) begin
            ctrl_d.state = ST_RECV;
            ctrl_d.cnt   = '0;
        end else if (accept) begin
            ctrl_d.cnt = ctrl_q.cnt + 1'b1;
            if (ctrl_q.cnt == LAST_IDX) begin
                ctrl_d.state = ST_FULL;
                ctrl_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.state <= ST_IDLE;
            ctrl_q.cnt   <= '0;
            ctrl_q.done  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign accept_o = accept;
    assign body_o   = accept && (ctrl_q.cnt < BODY_END);
    assign tail_o   = accept && (ctrl_q.cnt >= BODY_END);
    assign last_o   = accept && (ctrl_q.cnt == LAST_IDX);
    assign busy_o   = (ctrl_q.state == ST_RECV);
    assign cnt_o    = ctrl_q.cnt;
    assign done_o   = ctrl_q.done;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.done |=> !ctrl_q.done);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.cnt <= FULL_CNT));

    // R10
    clear_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (ctrl_q.cnt == '0) && (ctrl_q.state == ST_RECV) && !ctrl_q.done);
endmodule

// File: rtl/owa_crc_engine.sv
module owa_crc_engine #(
    parameter int                CRC_W = owa_pkg::CRC_W,
    parameter logic [CRC_W-1:0]  POLY  = owa_pkg::POLY_REFL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             body_en_i,
    input  logic             tail_en_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o,
    output logic [CRC_W-1:0] residue_o
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] res;
    } crc_s;

    crc_s crc_d, crc_q;

    function automatic logic [CRC_W-1:0] lfsr_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[0];
        return (c >> 1) ^ ({CRC_W{fb}} & POLY);
    endfunction

    always_comb begin
        crc_d = crc_q;
        if (clear_i) begin
            crc_d.crc = '0;
            crc_d.res = '0;
        end else begin
            if (body_en_i) begin
                crc_d.crc = lfsr_step(crc_q.crc, bit_i);
            end
            if (body_en_i || tail_en_i) begin
                crc_d.res = lfsr_step(crc_q.res, bit_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_o     = crc_q.crc;
    assign residue_o = crc_q.res;

    // R5
    tail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tail_en_i && !clear_i) |=> $stable(crc_q.crc));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (crc_q.crc == '0) && (crc_q.res == '0));
endmodule

// File: rtl/owa_addr_capture.sv
module owa_addr_capture #(
    parameter int ADDR_W = owa_pkg::ADDR_W,
    parameter int CNT_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic              bit_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clear_i) begin
            addr_d = '0;
        end else if (wr_en_i) begin
            for (int i = 0; i < ADDR_W; i++) begin
                if (idx_i == CNT_W'(i)) begin
                    addr_d[i] = bit_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

    // R4
    single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !clear_i) |=> ($countones(addr_q ^ $past(addr_q)) <= 1));
endmodule

// File: rtl/owa_addr_checker.sv
module owa_addr_checker #(
    parameter int                ADDR_W    = owa_pkg::ADDR_W,
    parameter int                CRC_W     = owa_pkg::CRC_W,
    parameter int                FAM_W     = owa_pkg::FAM_W,
    parameter int                SER_W     = owa_pkg::SER_W,
    parameter logic [CRC_W-1:0]  POLY      = owa_pkg::POLY_REFL,
    parameter logic [FAM_W-1:0]  FAMILY_ID = owa_pkg::FAMILY_ID
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    output logic [FAM_W-1:0] family_o,
    output logic [SER_W-1:0] serial_o,
    output logic [CRC_W-1:0] rx_crc_o,
    output logic [CRC_W-1:0] calc_crc_o,
    output logic             done_o,
    output logic             crc_ok_o,
    output logic             family_match_o
);
    localparam int BODY_W = FAM_W + SER_W;
    localparam int CNT_W  = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] FAM_DONE = CNT_W'(FAM_W);

    logic              accept, body_en, tail_en, last_bit, busy;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr;
    logic [CRC_W-1:0]  calc_crc, residue;
    logic [CRC_W-1:0]  rx_next;

    typedef struct packed {
        logic ok;
    } top_s;

    top_s top_d, top_q;

    owa_seq_ctrl #(.ADDR_W(ADDR_W), .BODY_W(BODY_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear_i),
        .bit_vld_i(bit_vld_i),
        .accept_o (accept),
        .body_o   (body_en),
        .tail_o   (tail_en),
        .last_o   (last_bit),
        .busy_o   (busy),
        .cnt_o    (cnt),
        .done_o   (done_o)
    );

    owa_crc_engine #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear_i),
        .body_en_i(body_en),
        .tail_en_i(tail_en),
        .bit_i    (bit_i),
        .crc_o    (calc_crc),
        .residue_o(residue)
    );

    owa_addr_capture #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .clear_i(clear_i),
        .wr_en_i(accept),
        .idx_i  (cnt),
        .bit_i  (bit_i),
        .addr_o (addr)
    );

    always_comb begin
        rx_next = {bit_i, addr[ADDR_W-2 -: CRC_W-1]};
        top_d   = top_q;
        if (clear_i) begin
            top_d.ok = 1'b0;
        end else if (last_bit) begin
            top_d.ok = (calc_crc == rx_next);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign family_o       = addr[FAM_W-1:0];
    assign serial_o       = addr[BODY_W-1:FAM_W];
    assign rx_crc_o       = addr[ADDR_W-1:BODY_W];
    assign calc_crc_o     = calc_crc;
    assign crc_ok_o       = top_q.ok;
    assign family_match_o = (cnt >= FAM_DONE) && (addr[FAM_W-1:0] == FAMILY_ID);

    // R7
    residue_agree_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((residue == '0) == crc_ok_o));

    // R7
    ok_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && !last_bit) |=> $stable(crc_ok_o));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !clear_i) |=> ($stable(addr) && $stable(calc_crc)));
endmodule

// File: tb/owa_addr_checker_test.sv
`timescale 1ns/1ps
module owa_addr_checker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        vld = 1'b0;
    logic        bin = 1'b0;
    logic [7:0]  family;
    logic [47:0] serial;
    logic [7:0]  rx_crc, calc_crc;
    logic        done, crc_ok, fmatch;

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    owa_addr_checker uut (
        .clk(clk), .rst(rst), .clear_i(clr), .bit_vld_i(vld), .bit_i(bin),
        .family_o(family), .serial_o(serial), .rx_crc_o(rx_crc),
        .calc_crc_o(calc_crc), .done_o(done), .crc_ok_o(crc_ok),
        .family_match_o(fmatch)
    );

    // behavioural reference model
    int          m_state = 0;
    int          m_cnt = 0;
    logic [63:0] m_addr = '0;
    logic        m_done = 1'b0;
    logic        m_ok = 1'b0;

    function automatic logic [7:0] crc_over(input logic [63:0] a, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            if (c[0] ^ a[i]) c = (c >> 1) ^ 8'h8C;
            else             c = c >> 1;
        end
        return c;
    endfunction

    always @(posedge clk) begin
        m_done = 1'b0;
        if (rst) begin
            m_state = 0; m_cnt = 0; m_addr = '0; m_ok = 1'b0;
        end else if (clr) begin
            m_state = 1; m_cnt = 0; m_addr = '0; m_ok = 1'b0;
        end else if (m_state == 1 && vld) begin
            m_addr[m_cnt] = bin;
            m_cnt++;
            if (m_cnt == 64) begin
                m_state = 2;
                m_done = 1'b1;
                m_ok = (crc_over(m_addr, 64) == 8'h00);
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 family", 64'(family), 64'(m_addr[7:0]));
            chk("R4 serial", 64'(serial), 64'(m_addr[55:8]));
            chk("R4 rx_crc", 64'(rx_crc), 64'(m_addr[63:56]));
            chk("R5 calc_crc", 64'(calc_crc), 64'(crc_over(m_addr, (m_cnt < 56) ? m_cnt : 56)));
            chk("R6 done", 64'(done), 64'(m_done));
            chk("R7 crc_ok", 64'(crc_ok), 64'(m_ok));
            chk("R9 family_match", 64'(fmatch), 64'((m_cnt >= 8) && (m_addr[7:0] == 8'h30)));
            if (done) done_cnt++;
        end
    end

    task automatic tick(input logic c, input logic v, input logic d);
        clr = c; vld = v; bin = d;
        @(negedge clk);
    endtask

    function automatic logic [63:0] make_addr(input logic [7:0] fam, input logic [47:0] ser, input logic good);
        logic [63:0] a;
        logic [7:0]  c;
        a = {8'h00, ser, fam};
        c = crc_over(a, 56);
        a[63:56] = good ? c : (c ^ 8'h5A);
        return a;
    endfunction

    task automatic send_bits(input logic [63:0] a, input int n, input logic gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (lfsr[0]) tick(1'b0, 1'b0, ~a[i]);
            end
            tick(1'b0, 1'b1, a[i]);
        end
    endtask

    task automatic frame(input string tag, input logic [63:0] a, input logic gaps, input logic exp_ok);
        tick(1'b1, 1'b0, 1'b0);
        done_cnt = 0;
        send_bits(a, 64, gaps);
        tick(1'b0, 1'b0, 1'b0);
        chk({tag, " R6 one done pulse"}, 64'(done_cnt), 64'd1);
        chk({tag, " R7 crc_ok"}, 64'(crc_ok), 64'(exp_ok));
        chk({tag, " R4 fields"}, {rx_crc, serial, family}, a);
        chk({tag, " R5 calc"}, 64'(calc_crc), 64'(crc_over(a, 56)));
    endtask

    initial begin
        logic [63:0] a, b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {rx_crc, serial, family}, 64'h0);
        chk("R1 reset flags", {56'h0, calc_crc}, 64'h0);
        chk("R1 reset done/ok/match", 64'({done, crc_ok, fmatch}), 64'h0);

        // R2 bits while idle are ignored
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, 1'b1);
        chk("R2 idle fields", {rx_crc, serial, family}, 64'h0);
        chk("R2 idle crc/done", 64'({calc_crc, done, crc_ok}), 64'h0);

        a = make_addr(8'h30, 48'h0123_4567_89AB, 1'b1);
        frame("F1", a, 1'b0, 1'b1);
        chk("R9 match after frame", 64'(fmatch), 64'd1);

        // R8 further bits ignored
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b1, ~a[i]);
        chk("R8 fields held", {rx_crc, serial, family}, a);
        chk("R8 ok held", 64'(crc_ok), 64'd1);

        frame("F2", make_addr(8'h28, 48'hFFFF_FFFF_FFFF, 1'b1), 1'b1, 1'b1);
        chk("R9 no match other family", 64'(fmatch), 64'd0);
        frame("F3", make_addr(8'h30, 48'hDEAD_BEEF_0042, 1'b0), 1'b1, 1'b0);
        frame("F4", 64'h0, 1'b0, 1'b1);
        frame("F5", make_addr(8'hA5, 48'h5555_AAAA_1234, 1'b1), 1'b1, 1'b1);

        // R3 clear and bit together: the bit is dropped
        tick(1'b1, 1'b1, 1'b1);
        chk("R3 clear clears ok", 64'(crc_ok), 64'd0);
        chk("R3 clear zeroes fields", {rx_crc, serial, family}, 64'h0);
        tick(1'b0, 1'b1, 1'b0);
        chk("R3 simultaneous bit dropped", 64'(family), 64'h0);

        // R10 abort mid-address then fresh address
        b = make_addr(8'h30, 48'h0F0F_0F0F_0F0F, 1'b1);
        send_bits(~b, 30, 1'b0);
        frame("R10 restart", b, 1'b0, 1'b1);

        // R3 clear on the final bit: no done, restart
        b = make_addr(8'h11, 48'h1357_9BDF_2468, 1'b1);
        tick(1'b1, 1'b0, 1'b0);
        done_cnt = 0;
        send_bits(b, 63, 1'b0);
        tick(1'b1, 1'b1, b[63]);
        tick(1'b0, 1'b0, 1'b0);
        chk("R3 clear beats last bit", 64'(done_cnt), 64'd0);
        chk("R3 fields after clear", {rx_crc, serial, family}, 64'h0);

        repeat (4) tick(1'b0, 1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule